// File: doc/BRIEF.md
# Display Palette Access Controller

This block holds the color lookup table of a display pipeline and gives a host processor register access to it. The table has 256 standard entries for 8-bit pixel indices. Three more entries sit above them: two cursor colors and one border (overscan) color. The host reaches the table through two 32-bit registers. The pointer register selects an entry. The data register reads or writes the selected entry, and every access to the data register moves the pointer on by one. A block of consecutive entries therefore needs only one pointer load, and the pointer must be reloaded before a jump to a non-consecutive entry.

The display side runs on the same clock. Each cycle it presents an 8-bit pixel index, two cursor select lines and a border flag. One cycle later it receives an 18-bit color. Whenever the host touches the data register, the display output holds its previous color for one extra clock. This keeps a half-updated entry from reaching the screen as a sparkle. A host write and a display lookup can fall in the same cycle. The write takes effect in that cycle, and the hold covers it.

Top module: `palette_port`

## Requirements
- R1: A write with `reg_sel`=0 loads `wdata[8:0]` into the pointer and ignores the upper bits. A read with `reg_sel`=0 returns the pointer zero-extended to 32 bits.
- R2: A data write (`reg_sel`=1) at pointer 0x000–0x0FF stores `wdata[17:0]` in the standard entry at that index. A data read returns the entry in bits 17:0, with bits 31:18 zero.
- R3: Pointer 0x100 addresses cursor color 0, pointer 0x101 addresses cursor color 1, and pointer 0x104 addresses the border color. All three can be both written and read.
- R4: A data write at pointer 0x102, 0x103 or 0x105–0x1FF changes no entry. A data read there returns zero.
- R5: Every data read or write increments the pointer by one, and the pointer wraps from 0x1FF to 0x000.
- R6: `color_out` shows the color selected by the previous cycle's display inputs. `border_on`=1 selects the border color. Otherwise `cur_sel[0]`=1 selects cursor 0, otherwise `cur_sel[1]`=1 selects cursor 1. In every other case the output is the standard entry at `pix_idx`.
- R7: A clock edge that comes with a data access leaves `color_out` unchanged. The next edge without an access updates it normally, and it then shows any entry written during the hold.
- R8: Read data appears on `rdata` one cycle after the read strobe and holds until the next read.
- R9: During and right after reset the pointer is 0x000, `rdata` is zero and `color_out` is zero.
- R10: When `wr_en` and `rd_en` are both high, only the write happens: `rdata` is unchanged and the pointer moves once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared host and pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| reg_sel | input | 1 | 0 = pointer register, 1 = data register |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, registered |
| pix_idx | input | 8 | Pixel color index |
| cur_sel | input | 2 | Bit 0 cursor color 0, bit 1 cursor color 1 |
| border_on | input | 1 | Border region active |
| color_out | output | 18 | Looked-up pixel color |

## Verification
Some behaviours are checked by the assertions on every cycle: the display hold on data accesses, the pointer step and load, the zero reserved bits of `rdata`, the stability of `rdata` between reads, and zero reads from invalid pointers. Other behaviours show only in the bench's scenarios: the priority between border, cursor and standard colors, the fact that ignored writes leave no trace, and the way a write made during a hold appears one cycle later. Those scenarios compare the outputs against a model of the table held in the bench.

// File: rtl/palette_port.sv
module palette_port #(
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 18,
  parameter int BUS_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic               reg_sel,
  input  logic [BUS_W-1:0]   wdata,
  output logic [BUS_W-1:0]   rdata,
  input  logic [IDX_W-1:0]   pix_idx,
  input  logic [1:0]         cur_sel,
  input  logic               border_on,
  output logic [COLOR_W-1:0] color_out
);
  localparam int PTR_W = IDX_W + 1;
  localparam int STD_N = 1 << IDX_W;
  localparam logic [PTR_W-1:0] A_CUR0 = PTR_W'(STD_N);
  localparam logic [PTR_W-1:0] A_CUR1 = PTR_W'(STD_N + 1);
  localparam logic [PTR_W-1:0] A_BORD = PTR_W'(STD_N + 4);

  logic [COLOR_W-1:0] std_mem [STD_N];
  logic [COLOR_W-1:0] cur0, cur1, bord;
  logic [PTR_W-1:0]   ptr;
  logic [COLOR_W-1:0] host_color, pix_color;

  wire acc    = reg_sel & (wr_en | rd_en);
  wire dwr    = reg_sel & wr_en;
  wire drd    = reg_sel & rd_en & ~wr_en;
  wire pwr    = ~reg_sel & wr_en;
  wire prd    = ~reg_sel & rd_en & ~wr_en;
  wire in_std = ~ptr[PTR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (pwr)  ptr <= wdata[PTR_W-1:0];
    else if (acc)  ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (dwr && in_std) std_mem[ptr[IDX_W-1:0]] <= wdata[COLOR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur0 <= '0;
      cur1 <= '0;
      bord <= '0;
    end else if (dwr) begin
      if (ptr == A_CUR0) cur0 <= wdata[COLOR_W-1:0];
      if (ptr == A_CUR1) cur1 <= wdata[COLOR_W-1:0];
      if (ptr == A_BORD) bord <= wdata[COLOR_W-1:0];
    end
  end

  always_comb begin
    if (in_std)              host_color = std_mem[ptr[IDX_W-1:0]];
    else if (ptr == A_CUR0)  host_color = cur0;
    else if (ptr == A_CUR1)  host_color = cur1;
    else if (ptr == A_BORD)  host_color = bord;
    else                     host_color = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   rdata <= '0;
    else if (drd) rdata <= {{(BUS_W-COLOR_W){1'b0}}, host_color};
    else if (prd) rdata <= {{(BUS_W-PTR_W){1'b0}}, ptr};
  end

  assign pix_color = border_on  ? bord :
                     cur_sel[0] ? cur0 :
                     cur_sel[1] ? cur1 : std_mem[pix_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)    color_out <= '0;
    else if (!acc) color_out <= pix_color;
  end
endmodule

// File: rtl/palette_port_chk.sv
module palette_port_chk #(
  parameter int PTR_W   = 9,
  parameter int STD_N   = 256,
  parameter int COLOR_W = 18,
  parameter int BUS_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic               reg_sel,
  input logic [BUS_W-1:0]   wdata,
  input logic [BUS_W-1:0]   rdata,
  input logic [COLOR_W-1:0] color_out,
  input logic [PTR_W-1:0]   ptr
);
  wire acc = reg_sel & (wr_en | rd_en);
  wire bad = (ptr == PTR_W'(STD_N + 2)) || (ptr == PTR_W'(STD_N + 3)) || (ptr >= PTR_W'(STD_N + 5));

  // R7
  hold_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> $stable(color_out));
  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ptr == PTR_W'($past(ptr) + 1'b1));
  // R1
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_sel) |=> ptr == $past(wdata[PTR_W-1:0]));
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !wr_en) |=> $stable(rdata));
  // R4
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && reg_sel && bad) |=> rdata == '0);
  // R2
  rsvd_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[BUS_W-1:COLOR_W] == '0);
endmodule

bind palette_port palette_port_chk #(
  .PTR_W(PTR_W), .STD_N(STD_N), .COLOR_W(COLOR_W), .BUS_W(BUS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
  .wdata(wdata), .rdata(rdata), .color_out(color_out), .ptr(ptr)
);

// File: tb/palette_port_test.sv
module palette_port_test;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, reg_sel = 0, border_on = 0;
  logic [31:0] wdata = 0;
  logic [7:0]  pix_idx = 0;
  logic [1:0]  cur_sel = 0;
  wire  [31:0] rdata;
  wire  [17:0] color_out;

  palette_port uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .pix_idx(pix_idx), .cur_sel(cur_sel),
    .border_on(border_on), .color_out(color_out));

  always #5 clk = ~clk;

  typedef struct { logic [31:0] v; string tag; } item_t;
  item_t q[$];
  int total = 0, fails = 0;
  bit done = 0;
  localparam logic [31:0] M = 32'h3FFFF;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial forever begin
    bit fire;
    @(posedge clk);
    fire = rd_en && !wr_en && rst_n;
    @(negedge clk);
    if (fire && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.tag, rdata, it.v);
    end
  end

  task automatic host(bit w, bit r, bit s, logic [31:0] d);
    wr_en = w; rd_en = r; reg_sel = s; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask
  task automatic set_ptr(logic [31:0] p); host(1, 0, 0, p); endtask
  task automatic put(logic [31:0] d); host(1, 0, 1, d); endtask
  task automatic get(bit s, logic [31:0] exp, string tag);
    item_t it;
    it.v = exp; it.tag = tag;
    q.push_back(it);
    host(0, 1, s, 0);
  endtask
  task automatic show(logic [7:0] idx, logic [1:0] cs, bit b, logic [31:0] exp, string tag);
    pix_idx = idx; cur_sel = cs; border_on = b;
    @(negedge clk);
    chk(tag, {14'd0, color_out}, exp);
  endtask

  logic [31:0] vals [4];
  localparam logic [31:0] C0 = 32'h0003_F000, C1 = 32'h0000_0FC0, OV = 32'h0002_AAAA;

  initial begin
    for (int i = 0; i < 4; i++) vals[i] = 32'hABCD_1234 + i * 32'h0101_0101;
    repeat (3) @(negedge clk);
    chk("R9 color", {14'd0, color_out}, 0);
    chk("R9 rdata", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    get(0, 0, "R9 ptr");

    set_ptr(32'hFFFF_FE10);
    get(0, 32'h10, "R1");
    for (int i = 0; i < 4; i++) put(vals[i]);
    get(0, 32'h14, "R5 step");
    set_ptr(32'h10);
    for (int i = 0; i < 4; i++) get(1, vals[i] & M, "R2");

    set_ptr(32'h100);
    put(C0); put(C1); put(32'h111); put(32'h222); put(OV);
    set_ptr(32'h100);
    get(1, C0, "R3 cur0"); get(1, C1, "R3 cur1");
    get(1, 0, "R4 0x102"); get(1, 0, "R4 0x103");
    get(1, OV, "R3 border");
    get(0, 32'h105, "R5 ptr");
    put(32'h3FFFF);
    set_ptr(32'h105);
    get(1, 0, "R4 0x105");
    set_ptr(32'h1FF);
    put(32'h1_5555);
    get(0, 0, "R5 wrap");
    put(32'h777);
    get(0, 1, "R5 after wrap");
    set_ptr(0);
    get(1, 32'h777, "R2 entry0");

    show(8'h11, 2'b00, 0, vals[1] & M, "R6 std");
    show(8'h11, 2'b01, 0, C0, "R6 cur0");
    show(8'h11, 2'b10, 0, C1, "R6 cur1");
    show(8'h11, 2'b11, 0, C0, "R6 both cursors");
    show(8'h11, 2'b11, 1, OV, "R6 border");
    show(8'h00, 2'b00, 0, 32'h777, "R6 idx0");

    show(8'h10, 2'b00, 0, vals[0] & M, "R6 idx10");
    set_ptr(32'h12);
    pix_idx = 8'h12;
    get(1, vals[2] & M, "R7 read data");
    chk("R7 read hold", {14'd0, color_out}, vals[0] & M);
    @(negedge clk);
    chk("R7 resume", {14'd0, color_out}, vals[2] & M);
    set_ptr(32'h12);
    put(32'h1357);
    chk("R7 write hold", {14'd0, color_out}, vals[2] & M);
    @(negedge clk);
    chk("R7 new entry", {14'd0, color_out}, 32'h1357);

    set_ptr(32'h13);
    host(1, 1, 1, 32'h2468);
    chk("R10 rdata kept", rdata, vals[2] & M);
    get(0, 32'h14, "R10 ptr once");
    set_ptr(32'h13);
    get(1, 32'h2468, "R10 written");
    @(negedge clk);
    chk("R8 rdata held", rdata, 32'h2468);

    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule